// File: doc/BRIEF.md
# Guarded Flash Erase/Program Controller

This block sits between a processor's register bus and a program-flash array and makes sure that no erase or program operation starts by accident. Software must write two key bytes to a key register, in order and with no other bus write between them, and then set a start bit as the very next bus write. Only then, and only when the write-enable bit is set and the region field selects program flash, does the controller launch an operation on the array.

A single start bit drives two operations. An erase-select bit in the same control write picks a row erase, aimed at the row that holds the table pointer. With the bit clear, the controller programs the contents of a small bank of holding registers into the block that holds the table pointer. Software fills those holding registers beforehand through a data port that steps the table pointer after each byte. While the operation runs, a CPU-stall output stays high for a fixed number of clock cycles given by a parameter, and for longer if the array has not yet signalled completion. The start bit reads back as 1 for that whole interval.

A start attempt that fails any of the guards has no effect on the array and sets a sticky error flag, which software clears by writing a 1 to it.

Top module: `nvm_guard_ctrl`

Register map on `bus_addr`: 0 = control, 1 = key, 2 = table pointer bits 7:0, 3 = table pointer upper bits, 4 = holding-register data port. Control bits: 0 = start (reads as busy), 2 = write enable, 3 = error (sticky, write 1 to clear), 4 = erase select, 7:6 = region (2'b10 selects program flash); bits 1 and 5 read 0.

## Requirements
- R1: A write of 8'h55 to the key register, then a write of 8'hAA to it, then a control write with bit 0 set as the next bus write launches an operation: one cycle after that write `cpu_stall` is 1 and control bit 0 reads 1. Bus cycles with `bus_we` low between these steps do not break the sequence.
- R2: A start attempt is rejected, with no erase or program pulse, if any bus write other than 8'hAA to the key register directly follows the 8'h55, if a repeated 8'h55 occurs, if any other bus write comes between the 8'hAA and the start write, or if no key was written at all.
- R3: A start attempt with control bit 2 (write enable) clear in the same write launches nothing.
- R4: A start attempt whose bits 7:6 are not 2'b10 launches nothing.
- R5: With bit 4 set, a launch gives a one-cycle `fl_erase` pulse and `fl_addr` equal to the table pointer with its low log2(ROW_BYTES) bits cleared. With bit 4 clear, it gives a one-cycle `fl_prog` pulse, `fl_addr` equal to the pointer with its low log2(BLK_BYTES) bits cleared, and `fl_wdata` byte i (bits 8i+7:8i) equal to holding register i.
- R6: `cpu_stall` and control bit 0 stay high for exactly STALL_CYCLES cycles when `fl_done` arrives within that time, and otherwise until the cycle after `fl_done` is sampled. Both fall in the same cycle.
- R7: Control writes while an operation runs are ignored: they launch nothing, set no error and leave the region, write-enable and erase-select fields unchanged.
- R8: A write to address 4 stores the byte in holding register number (pointer mod BLK_BYTES) and then adds 1 to the pointer. Reading address 4 returns that holding register, and reading addresses 2 and 3 returns the pointer.
- R9: A rejected start sets control bit 3. The bit stays set through later accepted operations and is cleared only by a control write with bit 3 set that is not itself a rejected start.
- R10: After reset, control reads 8'h00, the pointer reads 0, and `cpu_stall`, `fl_erase` and `fl_prog` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address of the previous cycle |
| cpu_stall | output | 1 | Holds the processor while an operation runs |
| fl_erase | output | 1 | One-cycle row-erase request to the array |
| fl_prog | output | 1 | One-cycle block-program request to the array |
| fl_addr | output | PTR_W | Aligned target address of the request |
| fl_wdata | output | 8*BLK_BYTES | Block data for a program request |
| fl_done | input | 1 | Array reports that the operation is finished |

## Verification
A table of control writes combines each key-sequence shape (complete, wrong second byte, repeated first byte, a stray write after the second byte, no key, a bus read in the middle) with region, write-enable and erase-select values. The bench then compares the launch decision, the pulse kind, the aligned address, the block data and the error bit. The complete and read-interleaved shapes separate a tracker that counts only bus writes from one that also reacts to idle bus cycles. The broken shapes separate a true back-to-back check from one that only remembers that both keys were seen. Directed cases cover an early and a late completion from the array, control writes during a running operation, error stickiness and pointer stepping.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_GOT55 = 2'd1,
    KEY_ARMED = 2'd2
  } key_st_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_KEY  = 3'd1;
  localparam logic [2:0] REG_PLO  = 3'd2;
  localparam logic [2:0] REG_PHI  = 3'd3;
  localparam logic [2:0] REG_HOLD = 3'd4;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int CTL_START = 0;
  localparam int CTL_WREN  = 2;
  localparam int CTL_ERR   = 3;
  localparam int CTL_ESEL  = 4;

  localparam logic [1:0] REGION_PROG = 2'b10;

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       armed
);

  key_st_e state;
  logic    key_wr;

  assign key_wr = wr_en && (wr_addr == REG_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= KEY_IDLE;
    end else if (wr_en) begin
      case (state)
        KEY_IDLE:  state <= (key_wr && wr_data == KEY_FIRST)  ? KEY_GOT55 : KEY_IDLE;
        KEY_GOT55: state <= (key_wr && wr_data == KEY_SECOND) ? KEY_ARMED : KEY_IDLE;
        default:   state <= KEY_IDLE;
      endcase
    end
  end

  assign armed = (state == KEY_ARMED);

  // R1: the armed state is entered only from the first-key state
  a_r1_armed_after_first: assert property (@(posedge clk) disable iff (rst)
    (state == KEY_ARMED) |-> ($past(state) == KEY_GOT55 || $past(state) == KEY_ARMED));

  // R2: any bus write leaves the armed state
  a_r2_armed_dropped_on_write: assert property (@(posedge clk) disable iff (rst)
    (state == KEY_ARMED && wr_en) |=> (state != KEY_ARMED));

  // R2: a write that is not the second key leaves the first-key state for idle
  a_r2_wrong_second_idle: assert property (@(posedge clk) disable iff (rst)
    (state == KEY_GOT55 && wr_en && !(key_wr && wr_data == KEY_SECOND)) |=> (state == KEY_IDLE));

endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int unsigned STALL_CYCLES = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic launch_erase,
  input  logic flash_done,
  output logic busy,
  output logic erase_pulse,
  output logic prog_pulse
);

  localparam int unsigned CW = $clog2(STALL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STALL_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          done_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cnt         <= '0;
      done_seen   <= 1'b0;
      erase_pulse <= 1'b0;
      prog_pulse  <= 1'b0;
    end else begin
      erase_pulse <= 1'b0;
      prog_pulse  <= 1'b0;
      if (launch && !busy) begin
        busy        <= 1'b1;
        cnt         <= '0;
        done_seen   <= 1'b0;
        erase_pulse <= launch_erase;
        prog_pulse  <= !launch_erase;
      end else if (busy) begin
        if (flash_done) done_seen <= 1'b1;
        if (cnt != LAST) cnt <= cnt + 1'b1;
        else if (done_seen || flash_done) busy <= 1'b0;
      end
    end
  end

  // R5: erase and program requests never coincide
  a_r5_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_pulse, prog_pulse}));

  // R5: a request appears only in the first busy cycle
  a_r5_pulse_at_start: assert property (@(posedge clk) disable iff (rst)
    (erase_pulse || prog_pulse) |-> (busy && !$past(busy)));

  // R6: the stall is not released before the full interval
  a_r6_min_interval: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == LAST));

  // R6: the stall is not released before the array reports completion
  a_r6_wait_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done_seen || flash_done));

endmodule

// File: rtl/nvm_hold_buf.sv
module nvm_hold_buf #(
  parameter int BLK_BYTES = 8,
  parameter int DW        = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(BLK_BYTES)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(BLK_BYTES)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data,
  input  logic                     snap_en,
  output logic [BLK_BYTES*DW-1:0]  snap
);

  logic [DW-1:0] mem [BLK_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_snap
    always_ff @(posedge clk) begin
      if (rst)          snap[g*DW +: DW] <= '0;
      else if (snap_en) snap[g*DW +: DW] <= mem[g];
    end
  end

endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
#(
  parameter int          PTR_W        = 16,
  parameter int          BLK_BYTES    = 8,
  parameter int          ROW_BYTES    = 64,
  parameter int unsigned STALL_CYCLES = 400000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_we,
  input  logic [2:0]              bus_addr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic                    cpu_stall,
  output logic                    fl_erase,
  output logic                    fl_prog,
  output logic [PTR_W-1:0]        fl_addr,
  output logic [8*BLK_BYTES-1:0]  fl_wdata,
  input  logic                    fl_done
);

  localparam int BLK_IW = $clog2(BLK_BYTES);
  localparam logic [PTR_W-1:0] BLK_MASK = PTR_W'(BLK_BYTES - 1);
  localparam logic [PTR_W-1:0] ROW_MASK = PTR_W'(ROW_BYTES - 1);

  logic             armed;
  logic             busy;
  logic [1:0]       region_q;
  logic             wren_q;
  logic             esel_q;
  logic             err_q;
  logic [PTR_W-1:0] ptr;
  logic [15:0]      ptr_ext;
  logic [7:0]       hold_rd;
  logic [7:0]       rdata_q;
  logic [2:0]       addr_q;
  logic             ctl_write;
  logic             start_try;
  logic             start_ok;
  logic             hold_we;

  assign ctl_write = bus_we && (bus_addr == REG_CTRL) && !busy;
  assign start_try = ctl_write && bus_wdata[CTL_START];
  assign start_ok  = start_try && armed && bus_wdata[CTL_WREN]
                     && (bus_wdata[7:6] == REGION_PROG);
  assign hold_we   = bus_we && (bus_addr == REG_HOLD);
  assign ptr_ext   = 16'(ptr);

  nvm_key_seq u_key (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_we),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .armed   (armed)
  );

  nvm_op_timer #(.STALL_CYCLES(STALL_CYCLES)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .launch       (start_ok),
    .launch_erase (bus_wdata[CTL_ESEL]),
    .flash_done   (fl_done),
    .busy         (busy),
    .erase_pulse  (fl_erase),
    .prog_pulse   (fl_prog)
  );

  nvm_hold_buf #(.BLK_BYTES(BLK_BYTES), .DW(8)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (hold_we),
    .wr_idx  (ptr[BLK_IW-1:0]),
    .wr_data (bus_wdata),
    .rd_idx  (ptr[BLK_IW-1:0]),
    .rd_data (hold_rd),
    .snap_en (start_ok),
    .snap    (fl_wdata)
  );

  // control fields and sticky error
  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= 2'b00;
      wren_q   <= 1'b0;
      esel_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (ctl_write) begin
      region_q <= bus_wdata[7:6];
      wren_q   <= bus_wdata[CTL_WREN];
      esel_q   <= bus_wdata[CTL_ESEL];
      if (start_try && !start_ok)  err_q <= 1'b1;
      else if (bus_wdata[CTL_ERR]) err_q <= 1'b0;
    end
  end

  // table pointer with auto-increment on holding writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (bus_we) begin
      if (bus_addr == REG_PLO)      ptr <= {ptr[PTR_W-1:8], bus_wdata};
      else if (bus_addr == REG_PHI) ptr <= PTR_W'({bus_wdata, ptr[7:0]});
      else if (hold_we)             ptr <= ptr + 1'b1;
    end
  end

  // latched target address
  always_ff @(posedge clk) begin
    if (rst)           fl_addr <= '0;
    else if (start_ok) fl_addr <= bus_wdata[CTL_ESEL] ? (ptr & ~ROW_MASK) : (ptr & ~BLK_MASK);
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= 8'h00;
      addr_q  <= 3'd0;
    end else begin
      addr_q <= bus_addr;
      case (bus_addr)
        REG_CTRL: rdata_q <= {region_q, 1'b0, esel_q, err_q, wren_q, 1'b0, busy};
        REG_PLO:  rdata_q <= ptr_ext[7:0];
        REG_PHI:  rdata_q <= ptr_ext[15:8];
        default:  rdata_q <= 8'h00;
      endcase
    end
  end

  assign bus_rdata = (addr_q == REG_HOLD) ? hold_rd : rdata_q;
  assign cpu_stall = busy;

  // R1/R2: an operation only starts from the armed key state
  a_r2_launch_needs_key: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));

  // R3: an operation only starts with write enable set
  a_r3_launch_needs_wren: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wren_q);

  // R4: an operation only starts with the program-flash region selected
  a_r4_launch_needs_region: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (region_q == REGION_PROG));

  // R5: an erase request carries a row-aligned address
  a_r5_erase_row_aligned: assert property (@(posedge clk) disable iff (rst)
    fl_erase |-> ((fl_addr & ROW_MASK) == '0));

  // R7: fields stay fixed while an operation runs
  a_r7_fields_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(region_q) && $stable(esel_q) && $stable(wren_q)));

  // R7: no error is raised while busy
  a_r7_no_err_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !$rose(err_q));

endmodule

// File: tb/tb_nvm_guard_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_guard_ctrl;

  localparam int STALL = 16;
  localparam int NV    = 11;
  // {region[7:6], wren[5], esel[4], mode[3:1], expect_launch[0]}
  // mode: 0 full key, 1 wrong second byte, 2 stray write after second byte,
  //       3 no key, 4 read between keys, 5 repeated first byte
  localparam logic [7:0] VEC [NV] = '{
    {2'b10, 1'b1, 1'b1, 3'd0, 1'b1},
    {2'b10, 1'b1, 1'b0, 3'd0, 1'b1},
    {2'b10, 1'b0, 1'b1, 3'd0, 1'b0},
    {2'b01, 1'b1, 1'b1, 3'd0, 1'b0},
    {2'b00, 1'b1, 1'b0, 3'd0, 1'b0},
    {2'b10, 1'b1, 1'b1, 3'd1, 1'b0},
    {2'b10, 1'b1, 1'b0, 3'd2, 1'b0},
    {2'b10, 1'b1, 1'b1, 3'd3, 1'b0},
    {2'b10, 1'b1, 1'b1, 3'd4, 1'b1},
    {2'b10, 1'b1, 1'b0, 3'd5, 1'b0},
    {2'b11, 1'b1, 1'b1, 3'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        cpu_stall;
  logic        fl_erase, fl_prog;
  logic [15:0] fl_addr;
  logic [63:0] fl_wdata;
  logic        fl_done = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // array model state
  int          launch_cnt = 0;
  int          done_dly = 4;
  int          dcnt = 0;
  bit          pend = 0;
  logic        cap_erase;
  logic [15:0] cap_addr;
  logic [63:0] cap_data;

  always #2.5 clk = ~clk;

  nvm_guard_ctrl #(.PTR_W(16), .BLK_BYTES(8), .ROW_BYTES(64), .STALL_CYCLES(STALL)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .fl_erase(fl_erase), .fl_prog(fl_prog),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_done(fl_done)
  );

  always @(negedge clk) begin
    if (fl_erase || fl_prog) begin
      launch_cnt++;
      cap_erase = fl_erase;
      cap_addr  = fl_addr;
      cap_data  = fl_wdata;
      pend = 1;
      dcnt = 1;
    end else if (pend) begin
      dcnt++;
    end
    if (pend && dcnt == done_dly) begin
      fl_done <= 1'b1;
      pend = 0;
    end else begin
      fl_done <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (cpu_stall === 1'b1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  r, v, ctl;
    logic [1:0]  region;
    logic        wren, esel, expl;
    logic [2:0]  mode;
    logic [15:0] target, base;
    logic [63:0] exp_data;
    int          n, n0;

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R10 reset state
    chk("R10 stall after reset", 64'(cpu_stall), 64'h0);
    chk("R10 requests after reset", 64'({fl_erase, fl_prog}), 64'h0);
    rd(3'd0, r); chk("R10 control after reset", 64'(r), 64'h00);
    rd(3'd2, r); chk("R10 pointer low after reset", 64'(r), 64'h00);
    rd(3'd3, r); chk("R10 pointer high after reset", 64'(r), 64'h00);

    // vector table: R1..R5 launch decision and outputs, R6 duration, R9 error
    for (int vi = 0; vi < NV; vi++) begin
      v = VEC[vi];
      region = v[7:6]; wren = v[5]; esel = v[4]; mode = v[3:1]; expl = v[0];
      target = 16'h1A05 + 16'(vi * 83);
      base   = target & ~16'h0007;
      wr(3'd2, base[7:0]); wr(3'd3, base[15:8]);
      exp_data = '0;
      for (int j = 0; j < 8; j++) begin
        exp_data[j*8 +: 8] = 8'(vi * 8 + j) ^ 8'hC3;
        wr(3'd4, exp_data[j*8 +: 8]);
      end
      wr(3'd2, target[7:0]); wr(3'd3, target[15:8]);
      n0 = launch_cnt;
      case (mode)
        3'd0: begin wr(3'd1, 8'h55); wr(3'd1, 8'hAA); end
        3'd1: begin wr(3'd1, 8'h55); wr(3'd1, 8'h5A); end
        3'd2: begin wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd2, target[7:0]); end
        3'd4: begin wr(3'd1, 8'h55); rd(3'd1, r); wr(3'd1, 8'hAA); end
        3'd5: begin wr(3'd1, 8'h55); wr(3'd1, 8'h55); wr(3'd1, 8'hAA); end
        default: ;
      endcase
      ctl = {region, 1'b0, esel, 1'b0, wren, 1'b0, 1'b1};
      wr(3'd0, ctl);
      idle();
      measure(n);
      chk($sformatf("R1/R2/R3/R4 launch count vector %0d", vi), 64'(launch_cnt - n0), 64'(expl));
      if (expl) begin
        chk($sformatf("R6 stall length vector %0d", vi), 64'(n), 64'(STALL));
        chk($sformatf("R5 request kind vector %0d", vi), 64'(cap_erase), 64'(esel));
        chk($sformatf("R5 address vector %0d", vi), 64'(cap_addr),
            64'(esel ? (target & ~16'h003F) : base));
        if (!esel) chk($sformatf("R5 block data vector %0d", vi), cap_data, exp_data);
      end else begin
        chk($sformatf("R2/R3/R4 no stall vector %0d", vi), 64'(n), 64'h0);
      end
      rd(3'd0, r);
      chk($sformatf("R9 control readback vector %0d", vi), 64'(r),
          64'({region, 1'b0, esel, ~expl, wren, 2'b00}));
      wr(3'd0, 8'h08); idle();
    end

    // R1/R7: start bit reads busy; control writes during the operation are ignored
    n0 = launch_cnt;
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h95); idle();
    rd(3'd0, r);
    chk("R1 start bit reads 1 while busy", 64'(r[0]), 64'h1);
    chk("R1 stall high while busy", 64'(cpu_stall), 64'h1);
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h45); idle();
    measure(n);
    rd(3'd0, r);
    chk("R7 fields unchanged after busy write", 64'(r), 64'h94);
    chk("R7 single launch", 64'(launch_cnt - n0), 64'h1);

    // R6: late completion from the array extends the stall
    done_dly = 25;
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h85); idle();
    measure(n);
    chk("R6 stall waits for late done", 64'(n), 64'd25);
    rd(3'd0, r);
    chk("R6 start bit clear with stall", 64'(r[0]), 64'h0);
    done_dly = 4;

    // R9: error is sticky across a good operation and cleared by writing 1
    wr(3'd0, 8'h85); idle();
    rd(3'd0, r); chk("R9 error set by bare start", 64'(r[3]), 64'h1);
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h85); idle();
    measure(n);
    rd(3'd0, r); chk("R9 error survives good operation", 64'(r[3]), 64'h1);
    wr(3'd0, 8'h08); idle();
    rd(3'd0, r); chk("R9 error cleared by write one", 64'(r[3]), 64'h0);

    // R8: pointer stepping and holding-register read
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    wr(3'd4, 8'hA1); wr(3'd4, 8'hB2); wr(3'd4, 8'hC3); idle();
    rd(3'd2, r); chk("R8 pointer low stepped", 64'(r), 64'h37);
    rd(3'd3, r); chk("R8 pointer high kept", 64'(r), 64'h12);
    wr(3'd2, 8'h35); idle();
    rd(3'd4, r); chk("R8 holding register readback", 64'(r), 64'hB2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule